// File: doc/BRIEF.md
# Link Delay-Fault Receiver Self-Test Controller

This block sits on the receive side of a handshaked point-to-point data link whose two ends run on unrelated clocks. It plays the receiver role of a two-wire handshake. The receiver raises a ready line when it will accept a word, and the sender raises a write strobe once the word is on the bus. The block exists to catch one kind of defect: data wires that settle later than the write strobe. Such a link hands over stale bits even though the handshake looks correct.

While the test enable is high, the data bus is captured on every receiver clock edge. For each transfer, the controller keeps two words: the one captured on the last edge before the write strobe reached the pins, and the one captured on the first edge after it. Both are compared with a known word taken from a small internal pattern table.

- A wrong word after the strobe proves the defect is present.
- A correct word before the strobe proves the defect is absent.
- Any other combination says nothing. The controller then asks for another transfer, up to a set number of tries, and gives up with an undecided verdict when the tries run out.

Top module: `lnk_dly_bist`

## Requirements
- R1: While reset is low, and while the test enable is low, `rtr_out`, `done`, `fault_present`, `fault_absent`, `inconclusive` and `proto_err` are all 0, whatever the write strobe does.
- R2: In test mode the controller raises `rtr_out` one cycle after the enable, and lowers it once a rising write strobe has passed the two-flop synchronizer. It raises it again, for the next try, only after the strobe is seen low. After a verdict it stays low.
- R3: The word captured on the first edge at which the strobe was high at the pins is compared with the expected word. If it differs, `fault_present` is set. This takes priority over R4.
- R4: The word captured on the edge just before that one is compared with the expected word. If it matches, and R3 did not fire, `fault_absent` is set.
- R5: A transfer that meets neither R3 nor R4 is one inconclusive try, and `done` stays low. If the try that would be the MAX_TRIES-th ends inconclusive, `inconclusive` is set instead. A decisive result on that last try still wins over `inconclusive`.
- R6: The expected word at table address a is SEED when a is even and ~SEED when a is odd. The address starts at 0 in each test session and advances by one per transfer, wrapping at DEPTH.
- R7: At most one of `fault_present`, `fault_absent` and `inconclusive` is ever 1. A verdict raises `done` together with exactly one of them. Both stay unchanged while the test enable is high, and both clear one cycle after it goes low.
- R8: In test mode, a synchronized write rise while `rtr_out` is low sets `proto_err`. So does a synchronized write fall while `rtr_out` is high. `proto_err` then holds until the test enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | Test enable from the sending side |
| wr_in | input | 1 | Asynchronous write strobe from the sender |
| data_in | input | W | Link data bus, asynchronous to clk |
| rtr_out | output | 1 | Ready-to-receive toward the sender |
| done | output | 1 | A verdict has been reached |
| fault_present | output | 1 | Late-data delay fault proven |
| fault_absent | output | 1 | Delay fault proven absent |
| inconclusive | output | 1 | Tries exhausted without a verdict |
| proto_err | output | 1 | Handshake rule broken by the sender |

## Verification
The hardest state to reach is a try that stays inconclusive: a correct word after the strobe but a stale word before it. That happens only when the data and the strobe both change inside one receiver clock period. The bench places data and strobe edges at fixed nanosecond offsets from a clock edge. Data a few nanoseconds ahead of the strobe, within one period, gives an inconclusive try. Data more than a period ahead gives absence, and data after the strobe gives presence. A short glitch back to the stale word, just after the strobe, exercises the priority of R3 over R4. Chains of inconclusive tries walk the address past its wrap point and up to the try limit.

// File: rtl/lnk_dly_pkg.sv
`timescale 1ns/1ps
// Shared types for the link delay-fault self-test controller.
package lnk_dly_pkg;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FIN   = 2'd3
    } ctl_state_t;

    // Latched verdict of one test session.
    typedef enum logic [1:0] {
        VD_NONE      = 2'd0,
        VD_PRESENT   = 2'd1,
        VD_ABSENT    = 2'd2,
        VD_UNDECIDED = 2'd3
    } verdict_t;

endpackage

// File: rtl/lnk_dly_wsync.sv
`timescale 1ns/1ps
// Write-strobe synchronizer.
// Brings the asynchronous strobe into the receiver domain through STAGES
// flops, and reports its level plus single-cycle rise and fall pulses.
// Assumes STAGES >= 2.
module lnk_dly_wsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              level_d;

    // Shift the strobe through the chain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain   <= '0;
            level_d <= 1'b0;
        end else begin
            chain   <= {chain[STAGES-2:0], async_in};
            level_d <= chain[STAGES-1];
        end
    end

    // Decode the synchronized level and its edges.
    always_comb begin
        level = chain[STAGES-1];
        rise  = level & ~level_d;
        fall  = ~level & level_d;
    end
endmodule

// File: rtl/lnk_dly_hist.sv
`timescale 1ns/1ps
// Data capture history.
// Registers the bus on every edge into TAPS+1 stages. With TAPS equal to the
// strobe synchronizer depth, on the cycle a synchronized rise is flagged:
//   post_word holds the bus from the first edge the strobe was high at the pins;
//   pre_word  holds the bus from the edge just before that one.
module lnk_dly_hist #(
    parameter int W    = 16,
    parameter int TAPS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] pre_word,
    output logic [W-1:0] post_word
);
    localparam int NSTG = TAPS + 1;

    logic [W-1:0] stg [NSTG];

    genvar k;
    generate
        for (k = 0; k < NSTG; k++) begin : g_stage
            if (k == 0) begin : g_first
                // Capture the raw bus.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= data_in;
                end
            end else begin : g_next
                // Age the previous capture by one edge.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[k] <= '0;
                    else        stg[k] <= stg[k-1];
                end
            end
        end
    endgenerate

    assign post_word = stg[TAPS-1];
    assign pre_word  = stg[TAPS];
endmodule

// File: rtl/lnk_dly_rom.sv
`timescale 1ns/1ps
// Expected-word table.
// Entry a holds SEED for even a and ~SEED for odd a, so that neighbouring
// entries (including the wrap from DEPTH-1 to 0) differ in every bit.
// Assumes DEPTH is even.
module lnk_dly_rom #(
    parameter int          W     = 16,
    parameter int          DEPTH = 4,
    parameter logic [W-1:0] SEED = '0,
    localparam int         AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0] addr,
    output logic [W-1:0]  word
);
    logic [W-1:0] table_q [DEPTH];

    genvar a;
    generate
        for (a = 0; a < DEPTH; a++) begin : g_ent
            assign table_q[a] = (a % 2 == 1) ? ~SEED : SEED;
        end
    endgenerate

    assign word = table_q[addr];
endmodule

// File: rtl/lnk_dly_ctl.sv
`timescale 1ns/1ps
// Test sequencer.
// Drives the ready line and judges each transfer from the two aligned
// captures against the expected word. It counts inconclusive tries, latches
// one verdict, and flags handshake-rule breaks. Everything is cleared while
// test_mode is low.
module lnk_dly_ctl
    import lnk_dly_pkg::*;
#(
    parameter int W         = 16,
    parameter int DEPTH     = 4,
    parameter int MAX_TRIES = 5,
    localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW       = $clog2(MAX_TRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          test_mode,
    input  logic          wr_level,
    input  logic          wr_rise,
    input  logic          wr_fall,
    input  logic [W-1:0]  pre_word,
    input  logic [W-1:0]  post_word,
    input  logic [W-1:0]  exp_word,
    output logic          rtr,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] inst_cnt,
    output verdict_t      verdict,
    output logic          done,
    output logic          perr
);
    ctl_state_t state;
    logic       post_bad, pre_good, last_try;
    logic [AW-1:0] addr_nx;

    // Per-transfer judgement terms.
    always_comb begin
        post_bad = (post_word != exp_word);
        pre_good = (pre_word == exp_word);
        last_try = (inst_cnt == CW'(MAX_TRIES - 1));
        addr_nx  = (addr == AW'(DEPTH - 1)) ? '0 : addr + AW'(1);
    end

    // Sequencing, judgement and protocol supervision.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_mode) begin
            state    <= ST_IDLE;
            rtr      <= 1'b0;
            addr     <= '0;
            inst_cnt <= '0;
            verdict  <= VD_NONE;
            perr     <= 1'b0;
        end else begin
            if (state != ST_IDLE && ((wr_rise && !rtr) || (wr_fall && rtr)))
                perr <= 1'b1;
            case (state)
                ST_IDLE: begin
                    state <= ST_ARM;
                    rtr   <= 1'b1;
                end
                ST_ARM: begin
                    if (wr_rise) begin
                        rtr  <= 1'b0;
                        addr <= addr_nx;
                        if (post_bad) begin
                            verdict <= VD_PRESENT;
                            state   <= ST_FIN;
                        end else if (pre_good) begin
                            verdict <= VD_ABSENT;
                            state   <= ST_FIN;
                        end else begin
                            inst_cnt <= inst_cnt + CW'(1);
                            if (last_try) begin
                                verdict <= VD_UNDECIDED;
                                state   <= ST_FIN;
                            end else begin
                                state <= ST_DRAIN;
                            end
                        end
                    end
                end
                ST_DRAIN: begin
                    if (!wr_level) begin
                        rtr   <= 1'b1;
                        state <= ST_ARM;
                    end
                end
                default: begin
                    state <= ST_FIN;
                end
            endcase
        end
    end

    assign done = (state == ST_FIN);
endmodule

// File: rtl/lnk_dly_bist.sv
`timescale 1ns/1ps
// Receiver-side delay-fault self-test for an asynchronous handshaked link.
// Assumes the sender holds test_mode steady during a session, and that DEPTH
// is even.
module lnk_dly_bist
    import lnk_dly_pkg::*;
#(
    parameter int           W          = 16,
    parameter int           DEPTH      = 4,
    parameter int           MAX_TRIES  = 5,
    parameter int           SYNC_STAGES = 2,
    parameter logic [W-1:0] SEED       = 16'h5A3C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         test_mode,
    input  logic         wr_in,
    input  logic [W-1:0] data_in,
    output logic         rtr_out,
    output logic         done,
    output logic         fault_present,
    output logic         fault_absent,
    output logic         inconclusive,
    output logic         proto_err
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(MAX_TRIES + 1);

    logic          wr_lvl, wr_rise, wr_fall;
    logic [W-1:0]  pre_word, post_word, exp_word;
    logic [AW-1:0] addr;
    logic [CW-1:0] inst_cnt;
    verdict_t      verdict;

    lnk_dly_wsync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk(clk), .rst_n(rst_n), .async_in(wr_in),
        .level(wr_lvl), .rise(wr_rise), .fall(wr_fall)
    );

    lnk_dly_hist #(.W(W), .TAPS(SYNC_STAGES)) u_hist (
        .clk(clk), .rst_n(rst_n), .data_in(data_in),
        .pre_word(pre_word), .post_word(post_word)
    );

    lnk_dly_rom #(.W(W), .DEPTH(DEPTH), .SEED(SEED)) u_rom (
        .addr(addr), .word(exp_word)
    );

    lnk_dly_ctl #(.W(W), .DEPTH(DEPTH), .MAX_TRIES(MAX_TRIES)) u_ctl (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .wr_level(wr_lvl), .wr_rise(wr_rise), .wr_fall(wr_fall),
        .pre_word(pre_word), .post_word(post_word), .exp_word(exp_word),
        .rtr(rtr_out), .addr(addr), .inst_cnt(inst_cnt),
        .verdict(verdict), .done(done), .perr(proto_err)
    );

    // Decode the latched verdict onto the result pins.
    always_comb begin
        fault_present = (verdict == VD_PRESENT);
        fault_absent  = (verdict == VD_ABSENT);
        inconclusive  = (verdict == VD_UNDECIDED);
    end
endmodule

// File: rtl/lnk_dly_bist_chk.sv
`timescale 1ns/1ps
// Property checker for lnk_dly_bist, attached through bind below.
module lnk_dly_bist_chk #(
    parameter int  MAX_TRIES = 5,
    localparam int CW        = $clog2(MAX_TRIES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          test_mode,
    input logic          rtr_out,
    input logic          done,
    input logic          fault_present,
    input logic          fault_absent,
    input logic          inconclusive,
    input logic          proto_err,
    input logic          wr_level,
    input logic [CW-1:0] inst_cnt
);
    p_verdict_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_present, fault_absent, inconclusive}));

    p_done_has_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones({fault_present, fault_absent, inconclusive}) == 1);

    p_verdict_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && test_mode) |=> (done && $stable({fault_present, fault_absent, inconclusive})));

    p_exit_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> (!rtr_out && !done && !fault_present && !fault_absent
                        && !inconclusive && !proto_err));

    p_rtr_drop_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rtr_out) && test_mode && $past(test_mode)) |-> $past(wr_level));

    p_try_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inst_cnt <= CW'(MAX_TRIES));

    p_perr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err && test_mode) |=> proto_err);
endmodule

bind lnk_dly_bist lnk_dly_bist_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .rtr_out(rtr_out),
    .done(done), .fault_present(fault_present), .fault_absent(fault_absent),
    .inconclusive(inconclusive), .proto_err(proto_err),
    .wr_level(wr_lvl), .inst_cnt(inst_cnt)
);

// File: tb/lnk_dly_bist_test.sv
`timescale 1ns/1ps
module lnk_dly_bist_test;
    localparam int           W     = 16;
    localparam int           DEPTH = 4;
    localparam int           TRIES = 5;
    localparam logic [W-1:0] SEED  = 16'h5A3C;

    // Transfer kinds: timing of data versus strobe relative to a clock edge.
    localparam int K_NONE = 0, K_GOOD = 1, K_BAD = 2, K_GLITCH = 3, K_INCON = 4;
    // Expected verdict codes.
    localparam int V_PRES = 1, V_ABS = 2, V_INC = 3;

    // Vector: {inconclusive tries[2:0], final kind[1:0], expected verdict[1:0]}
    localparam int NV = 7;
    localparam logic [6:0] VEC [NV] = '{
        {3'd0, 2'd1, 2'd2},   // one clean transfer -> absent
        {3'd0, 2'd2, 2'd1},   // late data -> present
        {3'd0, 2'd3, 2'd1},   // glitch: present outranks absent
        {3'd2, 2'd1, 2'd2},   // two undecided then clean
        {3'd3, 2'd2, 2'd1},   // three undecided then late data (address wraps)
        {3'd5, 2'd0, 2'd3},   // tries exhausted
        {3'd4, 2'd1, 2'd2}    // decisive on the last allowed try
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_mode = 1'b0;
    logic         wr_in = 1'b0;
    logic [W-1:0] data_in = '0;
    logic         rtr_out, done, fault_present, fault_absent, inconclusive, proto_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lnk_dly_bist #(.W(W), .DEPTH(DEPTH), .MAX_TRIES(TRIES), .SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .wr_in(wr_in),
        .data_in(data_in), .rtr_out(rtr_out), .done(done),
        .fault_present(fault_present), .fault_absent(fault_absent),
        .inconclusive(inconclusive), .proto_err(proto_err)
    );

    // R6: expected word for the i-th transfer of a session.
    function automatic logic [W-1:0] word_at(int i);
        return ((i % DEPTH) % 2 == 1) ? ~SEED : SEED;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_rtr(logic v);
        for (int n = 0; n < 100 && rtr_out !== v; n++) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int n = 0; n < 60 && done !== 1'b1; n++) @(negedge clk);
    endtask

    // One handshake with the given data/strobe skew.
    task automatic xfer(int kind, int idx);
        logic [W-1:0] w;
        w = word_at(idx);
        wait_rtr(1'b1);
        @(posedge clk);
        case (kind)
            K_GOOD:   begin #1 data_in = w; #11 wr_in = 1'b1; end
            K_INCON:  begin #1 data_in = w; #2 wr_in = 1'b1; end
            K_BAD:    begin #1 wr_in = 1'b1; #11 data_in = w; end
            default:  begin #1 data_in = w; #11 wr_in = 1'b1; #2 data_in = ~w; end
        endcase
        wait_rtr(1'b0);
        @(negedge clk);
        wr_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [2:0] verdict_bits(int v);
        case (v)
            V_PRES:  return 3'b100;
            V_ABS:   return 3'b010;
            V_INC:   return 3'b001;
            default: return 3'b000;
        endcase
    endfunction

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs idle in reset
        check({rtr_out, done, fault_present, fault_absent, inconclusive, proto_err} == 6'b0,
              "R1", "reset outputs", {rtr_out, done, fault_present, fault_absent, inconclusive, proto_err}, 0);
        rst_n = 1'b1;
        // R1: strobe activity outside test mode has no effect
        wr_in = 1'b1; repeat (4) @(negedge clk); wr_in = 1'b0; repeat (4) @(negedge clk);
        check({rtr_out, done, proto_err} == 3'b0, "R1", "idle outputs", {rtr_out, done, proto_err}, 0);

        for (int v = 0; v < NV; v++) begin
            int n, fin, ev;
            string rq;
            n   = int'(VEC[v][6:4]);
            fin = int'(VEC[v][3:2]);
            ev  = int'(VEC[v][1:0]);
            rq  = (ev == V_PRES) ? "R3" : (ev == V_ABS) ? "R4" : "R5";
            data_in   = ~SEED;
            test_mode = 1'b1;
            for (int i = 0; i < n; i++) begin
                xfer(K_INCON, i);
                if (i < TRIES - 1) begin
                    check(done == 1'b0, "R5", "no verdict after undecided try", done, 0);
                    check(rtr_out == 1'b1, "R2", "ready again after strobe low", rtr_out, 1);
                end
            end
            if (fin != K_NONE) xfer(fin, n);
            wait_done();
            check(done == 1'b1, rq, "done raised", done, 1);
            // verdict also depends on R6 words at each address
            check({fault_present, fault_absent, inconclusive} == verdict_bits(ev), rq,
                  "verdict (R6 words)", {fault_present, fault_absent, inconclusive}, verdict_bits(ev));
            check(rtr_out == 1'b0, "R2", "ready low after verdict", rtr_out, 0);
            check(proto_err == 1'b0, "R8", "no error on legal handshake", proto_err, 0);
            repeat (3) @(negedge clk);
            check({done, fault_present, fault_absent, inconclusive} == {1'b1, verdict_bits(ev)}, "R7",
                  "verdict latched", {done, fault_present, fault_absent, inconclusive}, {1'b1, verdict_bits(ev)});
            test_mode = 1'b0;
            repeat (2) @(negedge clk);
            check({rtr_out, done, fault_present, fault_absent, inconclusive} == 5'b0, "R7",
                  "cleared on exit", {rtr_out, done, fault_present, fault_absent, inconclusive}, 0);
        end

        // R8: strobe rises while ready is low (after a verdict)
        data_in = ~SEED;
        test_mode = 1'b1;
        xfer(K_GOOD, 0);
        wait_done();
        wr_in = 1'b1;
        repeat (5) @(negedge clk);
        check(proto_err == 1'b1, "R8", "rise while not ready", proto_err, 1);
        check({fault_present, fault_absent, inconclusive} == 3'b010, "R7",
              "verdict kept beside error", {fault_present, fault_absent, inconclusive}, 3'b010);
        wr_in = 1'b0;
        repeat (3) @(negedge clk);
        check(proto_err == 1'b1, "R8", "error sticky", proto_err, 1);
        test_mode = 1'b0;
        repeat (2) @(negedge clk);
        check(proto_err == 1'b0, "R8", "error cleared on exit", proto_err, 0);

        // R8: strobe falls while ready is high
        wr_in = 1'b1;
        repeat (4) @(negedge clk);
        test_mode = 1'b1;
        repeat (4) @(negedge clk);
        check(rtr_out == 1'b1, "R2", "ready raised on entry", rtr_out, 1);
        wr_in = 1'b0;
        repeat (4) @(negedge clk);
        check(proto_err == 1'b1, "R8", "fall while ready", proto_err, 1);
        check(done == 1'b0, "R8", "no verdict from bad fall", done, 0);
        test_mode = 1'b0;
        repeat (2) @(negedge clk);

        // R1: reset mid-session
        test_mode = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(rtr_out == 1'b0, "R1", "reset drops ready", rtr_out, 0);
        rst_n = 1'b1;
        test_mode = 1'b0;
        repeat (2) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule